// File: doc/BRIEF.md
# Predicated Vector Add Unit

This unit performs an elementwise integer add of two vector operands under control of a per-element predicate mask that it holds internally. The operands come from an external vector register file. The unit presents an element index on a read port and receives both source elements back in the same cycle. It returns each result through a single write port that carries its own write enable. A command is one of three things: an add, a reset of the mask to all-enabled, or a rebuild of the mask from a signed greater-than compare of one source vector against a scalar.

An add runs in one of two schemes, chosen for each command. In the sweep scheme, every element below the vector length takes one cycle, and the write enable is held low for predicated-off elements. In the skip scheme, the unit searches the mask and issues only the enabled elements, so a sparse mask finishes in fewer cycles. For the same inputs, both schemes leave the same register contents.

Top module: `masked_vadd_unit`

## Requirements
- R1: After reset, busy, done and wr_en are 0, cmd_ready is 1, and every bit of the mask (mask_o, bit i for element i) is 1.
- R2: Sweep add (cmd_op=0, cmd_dense=0) visits every element index below the vector length, one per cycle in ascending order, starting the cycle after acceptance. It is busy for max(VL,1) cycles, and wr_en is 1 only for elements whose mask bit is 1.
- R3: Skip add (cmd_op=0, cmd_dense=1) issues only the elements below the vector length whose mask bit is 1, one per cycle in ascending order, with wr_en 1 on every issued element. It is busy for max(count of such elements,1) cycles.
- R4: A write carries wr_idx equal to the element index and wr_data equal to rd_a+rd_b modulo 2^W, where rd_a and rd_b are the values returned for rd_idx = that element.
- R5: done is 1 in exactly the last busy cycle of an add or compare command, and busy falls after it.
- R6: Clear (cmd_op=1) sets all mask bits to 1 from the cycle after acceptance. It does not raise busy and writes nothing.
- R7: Compare (cmd_op=2) sets mask bit i, for i below the vector length, when the signed value rd_a for element i is greater than the signed cmd_scalar, and clears it otherwise. It clears the bits at or above the vector length, asserts no write, and is busy for max(VL,1) cycles.
- R8: Mask bits at or above the vector length never produce a write in either add scheme.
- R9: The sweep and skip schemes leave identical destination contents for the same operands, mask and vector length.
- R10: A command is accepted only when cmd_valid and cmd_ready are both 1, and cmd_ready is 0 while busy. A cmd_valid raised during a busy command has no effect.
- R11: A cmd_vl above VLMAX is treated as VLMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | 0 add, 1 clear mask, 2 compare into mask |
| cmd_dense | input | 1 | Add scheme: 0 sweep, 1 skip |
| cmd_vl | input | $clog2(VLMAX+1) | Vector length |
| cmd_scalar | input | W | Compare scalar (signed) |
| rd_idx | output | $clog2(VLMAX) | Element index to read |
| rd_a | input | W | First source element at rd_idx |
| rd_b | input | W | Second source element at rd_idx |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | $clog2(VLMAX) | Destination element index |
| wr_data | output | W | Destination element value |
| mask_o | output | VLMAX | Current mask, bit i for element i |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of a command |

## Verification
The hardest situation to reach is a skip add whose mask has set bits both below and above the vector length, together with a mask that has no enabled element at all, where the unit must still spend one cycle and raise done. The stimulus first builds such masks through the compare command, using operands whose signs are chosen against the scalar, and then runs each add in both schemes over the same operands and compares the two destination images. A stray cmd_valid is also raised partway through a run to show it is dropped.

// File: rtl/masked_vadd_unit.sv
module masked_vadd_unit #(
  parameter int VLMAX = 8,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic                       cmd_dense,
  input  logic [$clog2(VLMAX+1)-1:0] cmd_vl,
  input  logic [W-1:0]               cmd_scalar,
  output logic [$clog2(VLMAX)-1:0]   rd_idx,
  input  logic [W-1:0]               rd_a,
  input  logic [W-1:0]               rd_b,
  output logic                       wr_en,
  output logic [$clog2(VLMAX)-1:0]   wr_idx,
  output logic [W-1:0]               wr_data,
  output logic [VLMAX-1:0]           mask_o,
  output logic                       busy,
  output logic                       done
);
  localparam int IW = $clog2(VLMAX);
  localparam int LW = $clog2(VLMAX+1);
  localparam logic [1:0] OP_ADD = 2'd0, OP_CLR = 2'd1, OP_CMP = 2'd2;
  localparam logic [IW:0] NONE = (IW+1)'(VLMAX);

  logic              busy_q, dense_q;
  logic [1:0]        op_q;
  logic [LW-1:0]     vl_q, vl_in;
  logic [W-1:0]      scal_q;
  logic [IW:0]       scan_q, cur, nxt;
  logic [VLMAX-1:0]  mask_q, span_q, span_in, elig;
  logic              accept, have, last;

  function automatic logic [IW:0] seek(input logic [IW:0] from, input logic [VLMAX-1:0] ok);
    seek = NONE;
    for (int j = VLMAX-1; j >= 0; j--)
      if ((IW+1)'(j) >= from && ok[j]) seek = (IW+1)'(j);
  endfunction

  assign vl_in = (int'(cmd_vl) > VLMAX) ? LW'(VLMAX) : cmd_vl;

  always_comb begin
    for (int j = 0; j < VLMAX; j++) begin
      span_q[j]  = j < int'(vl_q);
      span_in[j] = j < int'(vl_in);
    end
  end

  assign elig   = ((dense_q && op_q == OP_ADD) ? mask_q : {VLMAX{1'b1}}) & span_q;
  assign cur    = seek(scan_q, elig);
  assign nxt    = seek(cur + 1'b1, elig);
  assign have   = busy_q && cur != NONE;
  assign last   = busy_q && (cur == NONE || nxt == NONE);
  assign accept = cmd_valid && !busy_q;

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = last;
  assign mask_o    = mask_q;
  assign rd_idx    = cur[IW-1:0];
  assign wr_idx    = cur[IW-1:0];
  assign wr_data   = rd_a + rd_b;
  assign wr_en     = have && op_q == OP_ADD && mask_q[cur[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dense_q <= 1'b0;
      op_q    <= OP_ADD;
      vl_q    <= '0;
      scal_q  <= '0;
      scan_q  <= '0;
      mask_q  <= '1;
    end else if (accept) begin
      if (cmd_op == OP_CLR) mask_q <= '1;
      if (cmd_op == OP_ADD || cmd_op == OP_CMP) begin
        busy_q  <= 1'b1;
        op_q    <= cmd_op;
        dense_q <= cmd_dense;
        vl_q    <= vl_in;
        scal_q  <= cmd_scalar;
        scan_q  <= '0;
      end
      if (cmd_op == OP_CMP) mask_q <= mask_q & span_in;
    end else if (busy_q) begin
      if (have && op_q == OP_CMP)
        mask_q[cur[IW-1:0]] <= $signed(rd_a) > $signed(scal_q);
      scan_q <= cur + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  a_r8_write_below_length: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_idx) < int'(vl_q));
  a_r5_done_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r6_clear_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_CLR) |=> (mask_o == {VLMAX{1'b1}} && !busy));
  a_r3_skip_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dense_q && op_q == OP_ADD && |(mask_q & span_q)) |-> wr_en);
  a_r10_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r7_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_CMP) |-> !wr_en);
endmodule

// File: tb/masked_vadd_unit_tb_top.sv
module masked_vadd_unit_tb_top;
  localparam int VLMAX = 8, W = 16, IW = 3, LW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_dense = 0, cmd_ready, wr_en, busy, done;
  logic [1:0] cmd_op = 0;
  logic [LW-1:0] cmd_vl = 0;
  logic [W-1:0] cmd_scalar = 0, rd_a, rd_b, wr_data;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [VLMAX-1:0] mask_o;

  logic [W-1:0] va [VLMAX], vb [VLMAX], vd [VLMAX], snap [VLMAX];
  logic [VLMAX-1:0] mref;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign rd_a = va[rd_idx];
  assign rd_b = vb[rd_idx];
  always @(posedge clk) if (wr_en) vd[wr_idx] <= wr_data;

  masked_vadd_unit #(.VLMAX(VLMAX), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dense(cmd_dense), .cmd_vl(cmd_vl), .cmd_scalar(cmd_scalar),
    .rd_idx(rd_idx), .rd_a(rd_a), .rd_b(rd_b), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .mask_o(mask_o), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // op: 0 add, 1 clear, 2 compare
  task automatic run(input int op, input bit dense, input int vl, input int scal, input bit stray);
    int ev, e[$], n;
    ev = (vl > VLMAX) ? VLMAX : vl;
    @(negedge clk);
    chk(cmd_ready == 1, "R10 ready idle", cmd_ready, 1);
    cmd_valid = 1; cmd_op = 2'(op); cmd_dense = dense; cmd_vl = LW'(vl); cmd_scalar = W'(scal);
    @(posedge clk); #1 cmd_valid = 0;
    if (op == 1) begin
      mref = '1;
      @(negedge clk);
      chk(mask_o == mref && !busy && !wr_en, "R6 clear", mask_o, mref);
      return;
    end
    if (op == 2) for (int j = ev; j < VLMAX; j++) mref[j] = 0;
    for (int j = 0; j < ev; j++) if (op != 0 || !dense || mref[j]) e.push_back(j);
    n = (e.size() > 0) ? e.size() : 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (stray && k == 0) begin cmd_valid = 1; cmd_op = 2'd1; end
      if (stray && k == 1) cmd_valid = 0;
      chk(busy == 1 && cmd_ready == 0, "R5 busy length", busy, 1);
      chk(done == (k == n-1), "R5 done last", done, k == n-1);
      if (e.size() == 0) chk(wr_en == 0, "R3 empty no write", wr_en, 0);
      else if (op == 2) begin
        chk(wr_en == 0 && int'(rd_idx) == e[k], "R7 compare scan", rd_idx, e[k]);
        mref[e[k]] = $signed(va[e[k]]) > $signed(W'(scal));
      end else begin
        chk(int'(rd_idx) == e[k], dense ? "R3 issue order" : "R2 issue order", rd_idx, e[k]);
        chk(wr_en == mref[e[k]], dense ? "R3 write enable" : "R2 write enable", wr_en, mref[e[k]]);
        if (mref[e[k]]) begin
          chk(int'(wr_idx) == e[k], "R4 write index", wr_idx, e[k]);
          chk(wr_data == W'(va[e[k]] + vb[e[k]]), "R4 sum", wr_data, W'(va[e[k]] + vb[e[k]]));
        end
      end
    end
    cmd_valid = 0;
    @(negedge clk);
    chk(busy == 0 && !wr_en, "R5 idle after done", busy, 0);
    chk(mask_o == mref, stray ? "R10 stray ignored" : "R7 mask state", mask_o, mref);
  endtask

  task automatic both(input int vl, input string tag);
    for (int j = 0; j < VLMAX; j++) vd[j] = 16'hdead;
    run(0, 0, vl, 0, 0);
    for (int j = 0; j < VLMAX; j++) begin snap[j] = vd[j]; vd[j] = 16'hdead; end
    run(0, 1, vl, 0, 0);
    for (int j = 0; j < VLMAX; j++) begin
      chk(vd[j] == snap[j], tag, vd[j], snap[j]);
      if (j >= ((vl > VLMAX) ? VLMAX : vl) || !mref[j])
        chk(vd[j] == 16'hdead, "R8 untouched", vd[j], 16'hdead);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end

  initial begin
    for (int j = 0; j < VLMAX; j++) begin
      va[j] = W'((j % 3 == 0) ? -(j+1) * 100 : j * 1000 + 7);
      vb[j] = W'(16'hfff0 + j * 9);
      vd[j] = 16'hdead;
    end
    mref = '1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && wr_en == 0 && cmd_ready == 1 && mask_o == '1, "R1 reset", mask_o, 8'hff);
    rst_n = 1;
    both(8, "R9 full mask");
    run(2, 0, 6, 0, 0);
    both(8, "R9 compare mask");
    both(5, "R9 short length");
    run(2, 0, 8, 5000, 0);
    both(8, "R9 sparse mask");
    run(2, 0, 8, 32000, 0);
    both(8, "R9 empty mask");
    run(0, 1, 0, 0, 0);
    run(0, 0, 0, 0, 0);
    run(1, 0, 8, 0, 0);
    chk(mask_o == 8'hff, "R6 all ones", mask_o, 8'hff);
    run(0, 0, 8, 0, 1);
    run(2, 0, 15, -1, 0);
    both(15, "R11 clamp");
    run(2, 0, 3, -32768, 0);
    both(8, "R8 above length");
    summary();
  end
endmodule